// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Accumulate Unit

This unit takes a vector of 32-bit words and, for each signed element in them, computes the high half of a doubled product added to an accumulator. The product of two multiplicands is doubled, optionally negated to give the multiply-subtract form, and added to the accumulator aligned to the upper half. A rounding bias can be added before the high half is taken. The high half is then clamped to the signed element range. Each 32-bit word of the vector holds either two independent 16-bit elements or one 32-bit element. One size control applies to the whole vector.

Operands and controls arrive together on a valid/ready input. Results leave on a valid/ready output after one register stage. The input is ready whenever the output register is empty or is being drained in the same cycle. While `out_ready` is low, a pending result stays unchanged. A sticky saturation flag records that at least one element of an accepted operation was clamped. The flag is cleared only by the plain `sat_clr` pin.

Top module: `sqrdm_lane_unit`

## Requirements
- R1: With `in_size`=0, each 16-bit element e (bits 15:0 and 31:16 of every word) returns sat16((a*b + (acc<<15) + rnd*(1<<14)) >>> 15) in the same bit positions. Elements do not affect each other.
- R2: With `in_size`=1, each 32-bit word returns sat32((a*b + (acc<<31) + rnd*(1<<30)) >>> 31), using a full 64-bit product.
- R3: With `in_neg`=1, the product is subtracted instead of added. The minimum-by-minimum product negates without wrapping.
- R4: With `in_round`=0, no rounding bias is added, so the shift truncates toward minus infinity.
- R5: A result above the element maximum returns 0x7FFF or 0x7FFFFFFF. A result below the minimum returns 0x8000 or 0x80000000.
- R6: `sat_flag` rises with the output of any accepted operation in which some element clamped, and then stays high. A high `sat_clr` clears it at the next edge, unless an operation that saturates is accepted in the same cycle, in which case the flag stays set.
- R7: Every 32-bit word of the vector is computed independently from the same word position of the three operands.
- R8: The output register holds its result at the port for as long as it waits.
  - A transfer accepted at an edge shows up as `out_valid`=1 after that edge.
  - `in_ready` = !`out_valid` | `out_ready`.
  - While `out_valid` is high and `out_ready` is low, `out_data` stays stable.
- R9: During and right after reset, `out_valid` and `sat_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls present |
| in_ready | output | 1 | Unit accepts input this cycle |
| in_size | input | 1 | 0: packed 16-bit elements, 1: 32-bit elements |
| in_neg | input | 1 | Subtract the doubled product |
| in_round | input | 1 | Add the rounding bias |
| in_mul_a | input | VW | First multiplicand vector |
| in_mul_b | input | VW | Second multiplicand vector |
| in_acc | input | VW | Accumulator vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VW | Result vector |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The bound checker watches the handshake on every cycle:
- an accepted transfer must show as valid;
- a stalled result must not move;
- a drained register with no new input must go empty;
- a set flag must stay set while no clear is requested.

Only the bench scenarios can show arithmetic correctness. They cover:
- minimum-by-minimum products under both negate settings;
- accumulators pinned at both extremes;
- the rounding bias that turns 0.5 into 1;
- lanes that saturate while their neighbours do not;
- clear and set in the same cycle.

Each result is compared with an independent full-precision model.

// File: rtl/sqrdm_pkg.sv
package sqrdm_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic {
    ESZ_HALF = 1'b0,
    ESZ_WORD = 1'b1
  } esz_e;
endpackage

// File: rtl/sqrdm_elem.sv
// One signed element: doubled product against a half-aligned accumulator,
// optional negate and rounding bias, high half, clamp.
module sqrdm_elem #(
  parameter int EW = 16
) (
  input  logic signed [EW-1:0] a,
  input  logic signed [EW-1:0] b,
  input  logic signed [EW-1:0] acc,
  input  logic                 neg,
  input  logic                 rnd,
  output logic        [EW-1:0] res,
  output logic                 sat
);
  localparam int PW  = 2 * EW;        // product width
  localparam int SW  = PW + 2;        // sum width with growth headroom
  localparam int SHW = SW - (EW - 1); // width after the right shift

  logic signed [PW-1:0]  prod;
  logic signed [SW-1:0]  prod_x, prod_s, acc_x, acc_sh, bias, sum;
  logic        [SHW-1:0] high;
  logic                  fits;
  logic                  unused_lo;

  assign prod   = a * b;
  assign prod_x = {{(SW-PW){prod[PW-1]}}, prod};
  assign prod_s = neg ? -prod_x : prod_x;
  assign acc_x  = {{(SW-EW){acc[EW-1]}}, acc};
  assign acc_sh = acc_x <<< (EW - 1);
  assign bias   = {{(SW-EW+1){1'b0}}, rnd, {(EW-2){1'b0}}};
  assign sum    = prod_s + acc_sh + bias;

  assign high      = sum[SW-1:EW-1];
  assign unused_lo = ^sum[EW-2:0];
  assign fits      = (&high[SHW-1:EW-1]) | ~(|high[SHW-1:EW-1]);

  always_comb begin
    if (fits)             res = high[EW-1:0];
    else if (high[SHW-1]) res = {1'b1, {(EW-1){1'b0}}};
    else                  res = {1'b0, {(EW-1){1'b1}}};
  end
  assign sat = ~fits;
endmodule

// File: rtl/sqrdm_word.sv
// One 32-bit word: two half-width elements or one full-width element.
module sqrdm_word
  import sqrdm_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] acc,
  input  esz_e              size,
  input  logic              neg,
  input  logic              rnd,
  output logic [WORD_W-1:0] res,
  output logic              sat
);
  logic [WORD_W-1:0] res_half;
  logic [1:0]        sat_half;
  logic [WORD_W-1:0] res_full;
  logic              sat_full;

  for (genvar h = 0; h < 2; h++) begin : g_half
    sqrdm_elem #(.EW(HALF_W)) u_elem (
      .a   (a[h*HALF_W +: HALF_W]),
      .b   (b[h*HALF_W +: HALF_W]),
      .acc (acc[h*HALF_W +: HALF_W]),
      .neg (neg),
      .rnd (rnd),
      .res (res_half[h*HALF_W +: HALF_W]),
      .sat (sat_half[h])
    );
  end

  sqrdm_elem #(.EW(WORD_W)) u_full (
    .a   (a),
    .b   (b),
    .acc (acc),
    .neg (neg),
    .rnd (rnd),
    .res (res_full),
    .sat (sat_full)
  );

  always_comb begin
    if (size == ESZ_WORD) begin
      res = res_full;
      sat = sat_full;
    end else begin
      res = res_half;
      sat = |sat_half;
    end
  end
endmodule

// File: rtl/sqrdm_lane_unit.sv
module sqrdm_lane_unit
  import sqrdm_pkg::*;
#(
  parameter int LANES = 2,
  localparam int VW   = LANES * WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_size,
  input  logic          in_neg,
  input  logic          in_round,
  input  logic [VW-1:0] in_mul_a,
  input  logic [VW-1:0] in_mul_b,
  input  logic [VW-1:0] in_acc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_data,
  input  logic          sat_clr,
  output logic          sat_flag
);
  logic [VW-1:0]    res_c;
  logic [LANES-1:0] sat_w;
  logic             take;
  esz_e             size_e;

  assign size_e   = esz_e'(in_size);
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  for (genvar w = 0; w < LANES; w++) begin : g_word
    sqrdm_word u_word (
      .a    (in_mul_a[w*WORD_W +: WORD_W]),
      .b    (in_mul_b[w*WORD_W +: WORD_W]),
      .acc  (in_acc[w*WORD_W +: WORD_W]),
      .size (size_e),
      .neg  (in_neg),
      .rnd  (in_round),
      .res  (res_c[w*WORD_W +: WORD_W]),
      .sat  (sat_w[w])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      sat_flag  <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_data  <= res_c;
      sat_flag <= (sat_flag & ~sat_clr) | (take & (|sat_w));
    end
  end
endmodule

// File: rtl/sqrdm_lane_chk.sv
module sqrdm_lane_chk #(
  parameter int VW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_data,
  input logic          sat_clr,
  input logic          sat_flag
);
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag);
endmodule

bind sqrdm_lane_unit sqrdm_lane_chk #(.VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .sat_clr   (sat_clr),
  .sat_flag  (sat_flag)
);

// File: tb/sqrdm_lane_unit_bench.sv
module sqrdm_lane_unit_bench;
  localparam int LANES = 2;
  localparam int VW    = LANES * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_size = 1'b0, in_neg = 1'b0, in_round = 1'b0;
  logic [VW-1:0] in_mul_a = '0, in_mul_b = '0, in_acc = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] out_data;
  logic          sat_clr = 1'b0;
  logic          sat_flag;

  always #5 clk = ~clk;

  sqrdm_lane_unit #(.LANES(LANES)) u_sqrdm_lane_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_size(in_size), .in_neg(in_neg), .in_round(in_round),
    .in_mul_a(in_mul_a), .in_mul_b(in_mul_b), .in_acc(in_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sat_clr(sat_clr), .sat_flag(sat_flag)
  );

  int    n_run  = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  string cur_tag = "R1";
  bit    bp_mode = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Full-precision reference for one element of width ew.
  function automatic logic [31:0] ref_el(input int ew, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] c, input bit ng, input bit rd,
      output bit sat);
    logic signed [127:0] sa, sb, sc, s, mx, mn;
    if (ew == 16) begin
      sa = $signed(a[15:0]); sb = $signed(b[15:0]); sc = $signed(c[15:0]);
    end else begin
      sa = $signed(a); sb = $signed(b); sc = $signed(c);
    end
    s = sa * sb;
    if (ng) s = -s;
    s = s + (sc <<< (ew - 1)) + (rd ? (128'sd1 <<< (ew - 2)) : 128'sd0);
    s = s >>> (ew - 1);
    mx = (128'sd1 <<< (ew - 1)) - 128'sd1;
    mn = -(128'sd1 <<< (ew - 1));
    sat = 1'b0;
    if (s > mx) begin s = mx; sat = 1'b1; end
    if (s < mn) begin s = mn; sat = 1'b1; end
    return (ew == 16) ? {16'h0, s[15:0]} : s[31:0];
  endfunction

  // Reference state: one pending result, its tag, and the sticky flag.
  logic [VW-1:0] q_data[$];
  string         q_tag[$];
  bit            m_flag = 1'b0;
  bit            last_acc = 1'b0;

  always @(posedge clk) begin
    bit mr, acc_now, any_sat, s0, s1;
    logic [VW-1:0] r;
    logic [31:0] lo, hi;
    if (!rst_n) begin
      q_data.delete(); q_tag.delete(); m_flag = 1'b0; last_acc = 1'b0;
    end else begin
      mr = (q_data.size() == 0) || out_ready;
      if (q_data.size() > 0 && out_ready) begin
        void'(q_data.pop_front()); void'(q_tag.pop_front());
      end
      acc_now = in_valid && mr;
      last_acc = acc_now;
      any_sat = 1'b0;
      if (acc_now) begin
        for (int w = 0; w < LANES; w++) begin
          if (in_size) begin
            r[w*32 +: 32] = ref_el(32, in_mul_a[w*32 +: 32], in_mul_b[w*32 +: 32],
                                   in_acc[w*32 +: 32], in_neg, in_round, s0);
            any_sat |= s0;
          end else begin
            lo = ref_el(16, {16'h0, in_mul_a[w*32 +: 16]}, {16'h0, in_mul_b[w*32 +: 16]},
                        {16'h0, in_acc[w*32 +: 16]}, in_neg, in_round, s0);
            hi = ref_el(16, {16'h0, in_mul_a[w*32+16 +: 16]}, {16'h0, in_mul_b[w*32+16 +: 16]},
                        {16'h0, in_acc[w*32+16 +: 16]}, in_neg, in_round, s1);
            r[w*32 +: 32] = {hi[15:0], lo[15:0]};
            any_sat |= s0 | s1;
          end
        end
        q_data.push_back(r);
        q_tag.push_back(cur_tag);
      end
      m_flag = (m_flag && !sat_clr) || any_sat;
    end
  end

  // Compare every clock, 2 ns after the edge, against the reference.
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check(out_valid == (q_data.size() > 0), "R8 out_valid",
            64'(out_valid), 64'(q_data.size() > 0));
      check(in_ready == ((q_data.size() == 0) || out_ready), "R8 in_ready",
            64'(in_ready), 64'((q_data.size() == 0) || out_ready));
      check(sat_flag == m_flag, "R6 sat_flag", 64'(sat_flag), 64'(m_flag));
      if (out_valid && q_data.size() > 0)
        check(out_data == q_data[0], q_tag[0], out_data, q_data[0]);
    end
  end

  always @(negedge clk) if (bp_mode) out_ready = 1'($urandom % 2);

  task automatic send(input bit sz, input bit ng, input bit rd,
                      input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [VW-1:0] c, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_size = sz; in_neg = ng; in_round = rd;
    in_mul_a = a; in_mul_b = b; in_acc = c; cur_tag = tag;
    do begin @(posedge clk); #1; end while (!last_acc);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] pick16();
    int k = $urandom % 4;
    return (k == 0) ? 16'h8000 : (k == 1) ? 16'h7fff : 16'($urandom);
  endfunction

  function automatic logic [VW-1:0] pick_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 16; i++) v[i*16 +: 16] = pick16();
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0 && sat_flag == 1'b0, "R9 reset state",
          {62'h0, out_valid, sat_flag}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && sat_flag == 1'b0, "R9 after reset",
          {62'h0, out_valid, sat_flag}, 64'h0);

    // R1 packed lanes, independent halves
    send(1'b0, 1'b0, 1'b1, {16'h4000, 16'h0003, 16'h1234, 16'hfff0},
         {16'h4000, 16'h7000, 16'h0100, 16'h0020},
         {16'h0000, 16'h0010, 16'hffff, 16'h0005}, "R1");
    // R4 rounding bias 0.5: on gives 1, off gives 0
    send(1'b0, 1'b0, 1'b1, {4{16'h0001}}, {4{16'h4000}}, '0, "R4 round on");
    send(1'b0, 1'b0, 1'b0, {4{16'h0001}}, {4{16'h4000}}, '0, "R4 round off");
    send(1'b0, 1'b0, 1'b0, {4{16'hffff}}, {4{16'h0001}}, '0, "R4 floor");
    idle(1);
    check(sat_flag == 1'b0, "R6 no saturation yet", 64'(sat_flag), 64'h0);
    // R3 negate, minimum-by-minimum without wrap
    send(1'b0, 1'b1, 1'b1, {4{16'h8000}}, {4{16'h8000}}, '0, "R3 neg min*min 16");
    send(1'b0, 1'b1, 1'b0, {4{16'h8000}}, {4{16'h8000}}, '0, "R3 neg min*min 16 no round");
    idle(1);
    check(sat_flag == 1'b0, "R3 neg min*min no clamp", 64'(sat_flag), 64'h0);
    // R5 clamps, 16-bit
    send(1'b0, 1'b0, 1'b1, {4{16'h8000}}, {4{16'h8000}}, '0, "R5 max 16");
    send(1'b0, 1'b0, 1'b1, {4{16'h7fff}}, {4{16'h7fff}}, {4{16'h7fff}}, "R5 acc max 16");
    send(1'b0, 1'b1, 1'b1, {4{16'h7fff}}, {4{16'h7fff}}, {4{16'h8000}}, "R5 acc min 16");
    // R2 32-bit elements
    send(1'b1, 1'b0, 1'b1, {32'h40000000, 32'h00012345}, {32'h40000000, 32'h00100000},
         {32'h00000007, 32'hfffffff0}, "R2");
    send(1'b1, 1'b1, 1'b1, {2{32'h80000000}}, {2{32'h80000000}}, '0, "R3 neg min*min 32");
    send(1'b1, 1'b0, 1'b1, {2{32'h80000000}}, {2{32'h80000000}}, '0, "R5 max 32");
    send(1'b1, 1'b1, 1'b0, {2{32'h7fffffff}}, {2{32'h7fffffff}}, {2{32'h80000000}}, "R5 min 32");
    send(1'b1, 1'b0, 1'b0, {32'h00000001, 32'h00010000}, {32'h40000000, 32'h00010000},
         {32'h7fffffff, 32'h00000000}, "R4 round off 32");
    // R7 word 0 clamps, word 1 does not
    send(1'b1, 1'b0, 1'b1, {32'h00000003, 32'h80000000}, {32'h00000005, 32'h80000000},
         {32'h00000011, 32'h00000000}, "R7 independent words");
    idle(2);
    check(sat_flag == 1'b1, "R6 sticky after clamp", 64'(sat_flag), 64'h1);
    // R6 clear, then clear in the same cycle as a saturating operation
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    check(sat_flag == 1'b0, "R6 cleared", 64'(sat_flag), 64'h0);
    send(1'b0, 1'b0, 1'b1, {4{16'h0002}}, {4{16'h0003}}, '0, "R6 benign op");
    idle(1);
    check(sat_flag == 1'b0, "R6 benign keeps clear", 64'(sat_flag), 64'h0);
    @(negedge clk);
    sat_clr = 1'b1; in_valid = 1'b1; in_size = 1'b0; in_neg = 1'b0; in_round = 1'b1;
    in_mul_a = {4{16'h8000}}; in_mul_b = {4{16'h8000}}; in_acc = '0; cur_tag = "R6 set wins";
    @(negedge clk);
    sat_clr = 1'b0; in_valid = 1'b0;
    check(sat_flag == 1'b1, "R6 set beats clear", 64'(sat_flag), 64'h1);
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;

    // R8 back-pressure with random mixed operands
    bp_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
           pick_vec(), pick_vec(), pick_vec(), "R8 random stream R1 R2 R3 R5");
      if ($urandom % 4 == 0) idle($urandom % 3);
    end
    idle(1);
    bp_mode = 1'b0;
    out_ready = 1'b1;
    idle(4);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule